// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block compares two single-precision floating-point operands. It reports the ordering as a one-hot condition code: less, greater, equal or unordered. It also raises an invalid-operation cause when a signalling NaN takes part and the invalid trap enable is set. The caller pulses `start` with both operands and the enable on the inputs. One cycle later `done` pulses, and the registered result is presented on the outputs.

The result stays on the outputs until the next compare replaces it. Every compare rebuilds the code field and the cause bit from nothing, so nothing carries over from an earlier compare. Denormal operands count as zeros of the same sign. The block does no arithmetic, no rounding and no trap dispatch.

Top module: `fcmp_unit`

## Requirements
- R1: After reset, `ccOut` is 0, `invCause` is 0 and `done` is 0.
- R2: `done` is 1 in exactly the cycle after each cycle in which `start` is 1, and 0 otherwise. Results are registered on the start edge and hold unchanged while `start` stays low, whatever the inputs do.
- R3: `ccOut` bit 3 means less, bit 2 greater, bit 1 equal and bit 0 unordered, and at most one bit is set. Each compare replaces both `ccOut` and `invCause`, so no value survives from the previous compare.
- R4: For ordered non-zero operands, `opA` below `opB` gives less, above gives greater, and identical values give equal. Values are ordered as signed numbers: between two negatives, the larger magnitude is the lesser value.
- R5: Positive zero and negative zero compare equal, in either order.
- R6: An operand with exponent field 0 and a non-zero fraction is a denormal. It is treated as zero: it equals any zero and any other denormal, and it is below the smallest positive normal.
- R7: A NaN has exponent field all ones and a non-zero fraction. It is quiet when fraction bit 22 is 1. A quiet NaN operand with no signalling NaN present gives unordered and no invalid cause.
- R8: A NaN with fraction bit 22 equal to 0 is signalling. If either operand is a signalling NaN and `invEn` is 0, the result is unordered with no invalid cause.
- R9: If either operand is a signalling NaN and `invEn` is 1, `invCause` is set and all four `ccOut` bits are 0.
- R10: Infinities (exponent all ones, fraction 0) are ordered values. Positive infinity is above every finite value, negative infinity is below every finite value, and equal infinities compare equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Compare request; operands and enable sampled on this cycle |
| invEn | input | 1 | Invalid-operation trap enable |
| opA | input | 32 | First operand, IEEE single precision |
| opB | input | 32 | Second operand, IEEE single precision |
| ccOut | output | 4 | Condition code {less, greater, equal, unordered} |
| invCause | output | 1 | Invalid-operation cause |
| done | output | 1 | One-cycle pulse marking a fresh result |

## Verification
Random operand pairs are drawn from a mix of ordinary bit patterns, zeros of both signs, denormals, infinities, quiet and signalling NaNs, and copies of the other operand. This mix covers ordering by sign and magnitude, zero and denormal equivalence, and the NaN priorities against the invalid enable. Directed pairs fix the corners that random drawing seldom reaches:
- two negatives whose order is the reverse of their magnitudes;
- a denormal against the smallest normal;
- a signalling NaN beside a quiet one;
- a trapped compare followed by an ordinary one, which shows that the cause is cleared.

Holding `start` low while the operands keep changing separates a registered result from one that follows the inputs.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int CC_W  = 4;
  localparam int CC_LT = 3;
  localparam int CC_GT = 2;
  localparam int CC_EQ = 1;
  localparam int CC_UN = 0;

  typedef struct packed {
    logic load;
  } fcmpCtrl_t;

  typedef struct packed {
    logic isNan;
    logic isSnan;
    logic isZero;
    logic sign;
  } opClass_t;
endpackage

// File: rtl/fcmp_class.sv
module fcmp_class
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] opIn,
  output opClass_t     cls,
  output logic [W-2:0] magOut
);
  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic expAllOnes, expAllZero;

  assign expField   = opIn[W-2 -: EXP_W];
  assign manField   = opIn[MAN_W-1:0];
  assign expAllOnes = &expField;
  assign expAllZero = ~|expField;

  always_comb begin
    cls.sign   = opIn[W-1];
    cls.isNan  = expAllOnes & (|manField);
    cls.isSnan = expAllOnes & (|manField) & ~manField[MAN_W-1];
    cls.isZero = expAllZero;
    // denormals collapse onto zero magnitude
    magOut     = expAllZero ? '0 : opIn[W-2:0];
  end
endmodule

// File: rtl/fcmp_dpath.sv
module fcmp_dpath
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  fcmpCtrl_t       ctl,
  input  logic [W-1:0]    opA,
  input  logic [W-1:0]    opB,
  input  logic            invEn,
  output logic [CC_W-1:0] ccQ,
  output logic            invQ
);
  logic [1:0][W-1:0] ops;
  opClass_t [1:0]    cls;
  logic [1:0][W-2:0] mag;

  assign ops[0] = opA;
  assign ops[1] = opB;

  for (genvar k = 0; k < 2; k++) begin : gClass
    fcmp_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) uClass (
      .opIn  (ops[k]),
      .cls   (cls[k]),
      .magOut(mag[k])
    );
  end

  logic [CC_W-1:0] ccNext;
  logic            invNext;
  logic            anySnan, anyNan, bothZero, magEq, magGt;

  always_comb begin
    anySnan  = cls[0].isSnan | cls[1].isSnan;
    anyNan   = cls[0].isNan | cls[1].isNan;
    bothZero = cls[0].isZero & cls[1].isZero;
    magEq    = mag[0] == mag[1];
    magGt    = mag[0] > mag[1];
    ccNext   = '0;
    invNext  = 1'b0;
    if (anySnan) begin
      if (invEn) invNext = 1'b1;
      else       ccNext[CC_UN] = 1'b1;
    end else if (anyNan) begin
      ccNext[CC_UN] = 1'b1;
    end else if (bothZero) begin
      ccNext[CC_EQ] = 1'b1;
    end else if (cls[0].sign != cls[1].sign) begin
      if (cls[0].sign) ccNext[CC_LT] = 1'b1;
      else             ccNext[CC_GT] = 1'b1;
    end else if (magEq) begin
      ccNext[CC_EQ] = 1'b1;
    end else if (magGt ^ cls[0].sign) begin
      ccNext[CC_GT] = 1'b1;
    end else begin
      ccNext[CC_LT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ccQ  <= '0;
      invQ <= 1'b0;
    end else if (ctl.load) begin
      ccQ  <= ccNext;
      invQ <= invNext;
    end
  end
endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output fcmpCtrl_t ctl,
  output logic      doneQ
);
  assign ctl.load = start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= start;
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            invEn,
  input  logic [W-1:0]    opA,
  input  logic [W-1:0]    opB,
  output logic [CC_W-1:0] ccOut,
  output logic            invCause,
  output logic            done
);
  fcmpCtrl_t ctl;

  fcmp_ctrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctl  (ctl),
    .doneQ(done)
  );

  fcmp_dpath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) uDpath (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .opA  (opA),
    .opB  (opB),
    .invEn(invEn),
    .ccQ  (ccOut),
    .invQ (invCause)
  );
endmodule

// File: rtl/fcmp_chk.sv
module fcmp_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       invEn,
  input logic [3:0] ccOut,
  input logic       invCause,
  input logic       done
);
  AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ($stable(ccOut) && $stable(invCause))); // R2
  AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ccOut)); // R3
  AST_DONE_HAS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (done && !invCause) |-> ($countones(ccOut) == 1)); // R3
  AST_TRAP_CLEARS_CC: assert property (@(posedge clk) disable iff (!rstN)
    invCause |-> (ccOut == 4'b0000)); // R9
  AST_NO_TRAP_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (start && !invEn) |=> !invCause); // R8
endmodule

bind fcmp_unit fcmp_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .invEn   (invEn),
  .ccOut   (ccOut),
  .invCause(invCause),
  .done    (done)
);

// File: tb/fcmp_unit_test.sv
`timescale 1ns/1ps
module fcmp_unit_test;
  localparam logic [3:0] LT = 4'b1000, GT = 4'b0100, EQ = 4'b0010, UN = 4'b0001;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, invEn = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [3:0] ccOut;
  logic invCause, done;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fcmp_unit uut (.clk(clk), .rstN(rstN), .start(start), .invEn(invEn),
                 .opA(opA), .opB(opB), .ccOut(ccOut), .invCause(invCause), .done(done));

  function automatic logic signed [33:0] keyOf(logic [31:0] x);
    logic signed [33:0] m;
    if (x[30:23] == 8'd0) return 34'sd0;
    m = $signed({3'b000, x[30:0]});
    return x[31] ? -m : m;
  endfunction

  function automatic logic [4:0] refCmp(logic [31:0] a, logic [31:0] b, logic en);
    logic na, nb, sa, sb;
    na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    sa = na && !a[22];
    sb = nb && !b[22];
    if (sa || sb) return en ? 5'b10000 : {1'b0, UN};
    if (na || nb) return {1'b0, UN};
    if (keyOf(a) < keyOf(b)) return {1'b0, LT};
    if (keyOf(a) > keyOf(b)) return {1'b0, GT};
    return {1'b0, EQ};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare(logic [31:0] a, logic [31:0] b, logic en, string req);
    logic [4:0] e;
    @(negedge clk);
    opA = a; opB = b; invEn = en; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e = refCmp(a, b, en);
    check(req, {invCause, ccOut}, e);
    check("R2 done", done, 1);
  endtask

  function automatic logic [31:0] pickOp(logic [31:0] other);
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 8)
      0: r = {r[31], 31'd0};
      1: r = {r[31], 8'd0, r[22:0]};
      2: r = {r[31], 8'hFF, 23'd0};
      3: r = {r[31], 8'hFF, 1'b1, r[21:0]};
      4: r = {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
      5: r = other;
      6: r = {r[31] ^ other[31], other[30:0]};
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    #1_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 cc", ccOut, 0);
    check("R1 cause", invCause, 0);
    check("R1 done", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    compare(32'h3F800000, 32'h40000000, 0, "R4 1<2");
    compare(32'h40000000, 32'h3F800000, 0, "R4 2>1");
    compare(32'h40490FDB, 32'h40490FDB, 1, "R4 equal");
    compare(32'hC0000000, 32'hBF800000, 0, "R4 -2<-1");
    compare(32'hBF800000, 32'h3F800000, 0, "R4 -1<1");
    compare(32'h80000000, 32'h00000000, 1, "R5 -0=+0");
    compare(32'h00000000, 32'h80000000, 0, "R5 +0=-0");
    compare(32'h00000001, 32'h80000000, 0, "R6 denorm=0");
    compare(32'h007FFFFF, 32'h00800000, 0, "R6 denorm<minnormal");
    compare(32'h807FFFFF, 32'h00400000, 0, "R6 denorm pair");
    compare(32'h7FC00000, 32'h3F800000, 1, "R7 qnan");
    compare(32'h3F800000, 32'hFFC00001, 1, "R7 qnan b");
    compare(32'h7F800001, 32'h3F800000, 0, "R8 snan off");
    compare(32'h7FC00000, 32'h7FA00000, 1, "R9 snan with qnan");
    compare(32'h3F800000, 32'hFF800001, 1, "R9 snan b");
    compare(32'h3F800000, 32'h3F800000, 1, "R3 cause cleared");
    compare(32'h7F800000, 32'h7F7FFFFF, 0, "R10 +inf>max");
    compare(32'hFF800000, 32'hFF7FFFFF, 0, "R10 -inf<-max");
    compare(32'h7F800000, 32'h7F800000, 1, "R10 inf=inf");
    // hold: outputs must not move while start stays low (R2)
    opA = 32'h7F800001; opB = 32'h0; invEn = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R2 hold", {invCause, ccOut}, {1'b0, EQ});
      check("R2 done low", done, 0);
      opA = $urandom; opB = $urandom;
    end
    for (int i = 0; i < 400; i++) begin
      a = pickOp(32'h3F800000);
      b = pickOp(a);
      compare(a, b, logic'($urandom % 2), "R3 R4 random");
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule